// File: doc/BRIEF.md
# Runway Wind Light Sequencer

This block drives a row of three indicator lamps placed at a runway end so that pilots can read the wind across the runway. A two-bit direction code selects one of three conditions. Each condition has its own repeating lamp pattern, and the block steps that pattern forward by one entry on every clock edge for as long as the code holds.

All three sequences share a single set of four states. Each state is one lamp pattern, and that pattern drives the output directly from a register. When the direction code changes, the next edge already produces a pattern from the new sequence. Entry may land at any point in the new cycle: the block takes the successor of the present pattern if that pattern belongs to the new sequence, and otherwise takes a fixed entry pattern.

Reset is synchronous and active low. It returns the lamps to the center-only pattern, which is a member of every sequence.

Top module: `runway_wind_lights`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `lamps` is 3'b010 after that edge.
- R2: With `wind_dir` = 2'b00 (calm), `lamps` alternates 3'b101 → 3'b010 → 3'b101, one step per edge. From 3'b100 or 3'b001 the next pattern is 3'b010.
- R3: With `wind_dir` = 2'b01 (right-to-left), `lamps` steps 3'b001 → 3'b010 → 3'b100 → 3'b001. From 3'b101 the next pattern is 3'b001.
- R4: With `wind_dir` = 2'b10 (left-to-right), `lamps` steps 3'b100 → 3'b010 → 3'b001 → 3'b100. From 3'b101 the next pattern is 3'b100.
- R5: A change of `wind_dir` between two edges takes effect at the first edge after the change. The pattern produced there follows the R2–R4 rule for the new code, applied to the pattern present before that edge.
- R6: With `wind_dir` = 2'b11 (not a legal code), the next pattern is 3'b010. The machine then resumes any legal sequence from there.
- R7: Outside reset, `lamps` is always one of 3'b101, 3'b010, 3'b100 or 3'b001. Bit [2] is the leftmost lamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wind_dir | input | 2 | Direction code: 00 calm, 01 right-to-left, 10 left-to-right |
| lamps | output | 3 | Lamp pattern, bit 2 leftmost, bit 0 rightmost |

## Verification
The output is the state itself. A corrupted state therefore appears on `lamps` in the same cycle, either as a pattern outside the legal four or as a legal pattern that is the wrong successor. The fault is visible one edge after the step that went wrong. The bench compares every edge against a successor table built from the requirements. It covers each direction code, a switch from every pattern into every sequence, the illegal code, and a reset applied mid-sequence.

// File: rtl/wind_lights_pkg.sv
// Package: shared lamp width, direction codes and lamp pattern constants.
// Assumes bit [LAMP_W-1] is the leftmost lamp.
package wind_lights_pkg;

    localparam int LAMP_W = 3;
    localparam int DIR_W  = 2;

    typedef enum logic [DIR_W-1:0] {
        WIND_CALM = 2'b00,
        WIND_R2L  = 2'b01,
        WIND_L2R  = 2'b10,
        WIND_BAD  = 2'b11
    } wind_e;

    typedef logic [LAMP_W-1:0] lamp_t;

    localparam lamp_t PAT_OUTER = 3'b101;
    localparam lamp_t PAT_MID   = 3'b010;
    localparam lamp_t PAT_LEFT  = 3'b100;
    localparam lamp_t PAT_RIGHT = 3'b001;

endpackage

// File: rtl/wind_dir_decode.sv
// Module: turns the raw direction code into the mode type.
// Assumes the code 2'b11 is never driven on purpose; it is passed on as
// WIND_BAD so that the step logic can recover from it.
module wind_dir_decode
    import wind_lights_pkg::*;
(
    input  logic [DIR_W-1:0] dir_code,
    output wind_e            mode
);

    // Purpose: one-to-one cast of the code onto the enum.
    always_comb begin
        mode = wind_e'(dir_code);
    end

endmodule

// File: rtl/lamp_step_logic.sv
// Module: next-pattern function shared by all three sequences.
// Assumes cur_pat is the registered pattern. Any value outside the legal four
// is sent to the center pattern.
module lamp_step_logic
    import wind_lights_pkg::*;
(
    input  wind_e mode,
    input  lamp_t cur_pat,
    output lamp_t nxt_pat
);

    logic cur_legal;

    // Purpose: flag whether the present pattern is one of the four states.
    always_comb begin
        cur_legal = (cur_pat == PAT_OUTER) || (cur_pat == PAT_MID) ||
                    (cur_pat == PAT_LEFT)  || (cur_pat == PAT_RIGHT);
    end

    // Purpose: pick the successor for the selected sequence.
    always_comb begin
        nxt_pat = PAT_MID;
        if (cur_legal) begin
            unique case (mode)
                WIND_CALM: nxt_pat = (cur_pat == PAT_MID) ? PAT_OUTER : PAT_MID;
                WIND_R2L: begin
                    if (cur_pat == PAT_RIGHT)     nxt_pat = PAT_MID;
                    else if (cur_pat == PAT_MID)  nxt_pat = PAT_LEFT;
                    else                          nxt_pat = PAT_RIGHT;
                end
                WIND_L2R: begin
                    if (cur_pat == PAT_LEFT)      nxt_pat = PAT_MID;
                    else if (cur_pat == PAT_MID)  nxt_pat = PAT_RIGHT;
                    else                          nxt_pat = PAT_LEFT;
                end
                WIND_BAD:  nxt_pat = PAT_MID;
            endcase
        end
    end

endmodule

// File: rtl/lamp_pattern_reg.sv
// Module: pattern register with synchronous active-low reset.
// Assumes the reset value is a legal pattern.
module lamp_pattern_reg #(
    parameter int                 WIDTH     = 3,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Purpose: hold the present pattern; load reset value when rst_n is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/runway_wind_lights.sv
// Module: top of the runway wind light sequencer.
// The registered pattern is both the state and the lamp output.
// Assumes wind_dir is synchronous to clk.
module runway_wind_lights
    import wind_lights_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIR_W-1:0]  wind_dir,
    output logic [LAMP_W-1:0] lamps
);

    wind_e mode;
    lamp_t cur_pat;
    lamp_t nxt_pat;

    wind_dir_decode i_decode (
        .dir_code (wind_dir),
        .mode     (mode)
    );

    lamp_step_logic i_step (
        .mode    (mode),
        .cur_pat (cur_pat),
        .nxt_pat (nxt_pat)
    );

    lamp_pattern_reg #(
        .WIDTH     (LAMP_W),
        .RESET_VAL (PAT_MID)
    ) i_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_pat),
        .q     (cur_pat)
    );

    // Purpose: drive the lamps straight from the state register.
    always_comb begin
        lamps = cur_pat;
    end

endmodule

// File: rtl/runway_wind_lights_chk.sv
// Module: property checker for runway_wind_lights, bound below.
module runway_wind_lights_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] wind_dir,
    input logic [2:0] lamps
);

    logic seen_edge = 1'b0;

    // Purpose: mark that at least one edge has passed, so $past is valid.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    // R1
    reset_mid_chk: assert property (@(posedge clk)
        seen_edge && !$past(rst_n) |-> lamps == 3'b010);

    // R2
    calm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && wind_dir == 2'b00 |=> lamps == ($past(lamps) == 3'b010 ? 3'b101 : 3'b010));

    // R3
    r2l_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && wind_dir == 2'b01 && lamps == 3'b010 |=> lamps == 3'b100);

    // R4
    l2r_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && wind_dir == 2'b10 && lamps == 3'b010 |=> lamps == 3'b001);

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && wind_dir == 2'b11 |=> lamps == 3'b010);

    // R7
    legal_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && $past(rst_n) |-> (lamps == 3'b101 || lamps == 3'b010 ||
                                       lamps == 3'b100 || lamps == 3'b001));

endmodule

bind runway_wind_lights runway_wind_lights_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wind_dir (wind_dir),
    .lamps    (lamps)
);

// File: tb/test_runway_wind_lights.sv
module test_runway_wind_lights;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wind_dir = 2'b00;
    logic [2:0] lamps;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    runway_wind_lights i_runway_wind_lights (
        .clk      (clk),
        .rst_n    (rst_n),
        .wind_dir (wind_dir),
        .lamps    (lamps)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Successor table taken from R2, R3, R4 and R6.
    function automatic logic [2:0] succ(input logic [1:0] d, input logic [2:0] p);
        case (d)
            2'b00: return (p == 3'b010) ? 3'b101 : 3'b010;
            2'b01: return (p == 3'b001) ? 3'b010 : (p == 3'b010) ? 3'b100 : 3'b001;
            2'b10: return (p == 3'b100) ? 3'b010 : (p == 3'b010) ? 3'b001 : 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: lamps=%b expected=%b", req, got, exp);
        end
    endtask

    // Drive inputs at the falling edge, then sample 1 time unit after the rising edge.
    task automatic step(input logic [1:0] d, input logic r);
        @(negedge clk);
        wind_dir = d;
        rst_n    = r;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        step(2'b01, 1'b0);
        check("R1", lamps, 3'b010);
        step(2'b00, 1'b0);
        check("R1", lamps, 3'b010);
    endtask

    task automatic t_calm;
        logic [2:0] e;
        e = lamps;
        for (int i = 0; i < 5; i++) begin
            e = succ(2'b00, e);
            step(2'b00, 1'b1);
            check("R2", lamps, e);
        end
    endtask

    task automatic t_r2l;
        step(2'b01, 1'b1);
        check("R3", lamps, succ(2'b01, 3'b101));
        step(2'b01, 1'b1); check("R3", lamps, 3'b010);
        step(2'b01, 1'b1); check("R3", lamps, 3'b100);
        step(2'b01, 1'b1); check("R3", lamps, 3'b001);
    endtask

    task automatic t_l2r;
        step(2'b10, 1'b1); check("R4", lamps, 3'b100);
        step(2'b10, 1'b1); check("R4", lamps, 3'b010);
        step(2'b10, 1'b1); check("R4", lamps, 3'b001);
        step(2'b10, 1'b1); check("R4", lamps, 3'b100);
    endtask

    task automatic t_switch;
        logic [2:0] e;
        e = lamps;
        for (int i = 0; i < 24; i++) begin
            logic [1:0] d;
            d = 2'((i * 7 + i / 3) % 3);
            e = succ(d, e);
            step(d, 1'b1);
            check("R5", lamps, e);
        end
        // From the outer pattern into each crosswind.
        step(2'b00, 1'b1);
        if (lamps != 3'b101) step(2'b00, 1'b1);
        step(2'b10, 1'b1); check("R5", lamps, 3'b100);
        step(2'b00, 1'b1); check("R5", lamps, 3'b010);
        step(2'b00, 1'b1); check("R5", lamps, 3'b101);
        step(2'b01, 1'b1); check("R5", lamps, 3'b001);
        step(2'b00, 1'b1); check("R5", lamps, 3'b010);
    endtask

    task automatic t_bad_code;
        step(2'b10, 1'b1);
        step(2'b11, 1'b1); check("R6", lamps, 3'b010);
        step(2'b11, 1'b1); check("R6", lamps, 3'b010);
        step(2'b01, 1'b1); check("R6", lamps, 3'b100);
    endtask

    task automatic t_legal_and_midreset;
        for (int i = 0; i < 12; i++) begin
            step(2'(i % 4), 1'b1);
            check("R7", {2'b00, ($countones(lamps) == 1 || lamps == 3'b101)}, 3'b001);
        end
        step(2'b10, 1'b1);
        step(2'b10, 1'b0); check("R1", lamps, 3'b010);
    endtask

    initial begin
        t_reset();
        t_calm();
        t_r2l();
        t_l2r();
        t_switch();
        t_bad_code();
        t_legal_and_midreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule